// File: doc/BRIEF.md
# Neighborhood Pattern Sensitive Fault Tester

This block is a built-in self-test controller for a bit-wide memory laid out as a grid of `ROWS` by `COLS` cells. Cell (row, col) sits at linear address `row*COLS + col`. The grid is split like a checkerboard. Cells whose row plus column is even are *base* cells. Every other cell is a *neighbor* cell and belongs to the north, south, east or west surroundings of up to four base cells.

The controller runs two phases. Phase 0 holds every base cell at 0 and phase 1 holds every base cell at 1. In each phase it walks the four surrounding cells of every base cell through all sixteen 4-bit combinations. The combinations follow a Gray order, so each step flips only one neighbor position. After every step it reads back every base cell. Any base cell that a surrounding pattern disturbs, or holds at a fixed value, therefore shows up as a mismatch. The first mismatch is captured with its address and the value that was expected. A done flag marks the end of both phases.

The memory port is synchronous, with one cycle of read latency. Software starts a run with a single-cycle `start` pulse and then watches `done` and `fail`.

Top module: `npsf_tester`

## Requirements
- R1: While `rst_n` is low, and after its release, `busy`, `done`, `fail` and `mem_we` are all 0.
- R2: A `start` pulse while idle or done begins a test, and `busy` is 1 from the next cycle. A `start` pulse while `busy` is 1 has no effect on the operation sequence.
- R3: Cell (r, c) uses address r*COLS+c. A cell is a base cell when r+c is even. All other cells are neighbor cells.
- R4: Each phase has 16 steps, s = 0..15, and uses the pattern g = s XOR (s>>1). Each step is a write sweep over addresses 0..CELLS-1 in ascending order, one address per cycle. A read sweep over the same addresses in the same order follows it. Phase 0 runs before phase 1.
- R5: In a write sweep, neighbor cell (r, c) has position class k = 2*(r mod 2) + ((r>>1) XOR (c>>1)) mod 2, and receives bit k of g. Base cells are written only in step 0, with the phase value. In other steps, `mem_we` is 0 at base addresses.
- R6: In a read sweep, `mem_we` is 0. The `mem_rdata` returned one cycle after a base address is compared with the phase value. Data returned for neighbor addresses is ignored.
- R7: Base cells on the array edges and in the corners are read and compared like interior cells. Only the neighbors that exist take part in their patterns.
- R8: The first mismatch sets `fail` and latches `fail_addr` and `fail_exp` (the expected bit). Later mismatches change none of these outputs. A new `start` clears all three.
- R9: One cycle after the last read of phase 1, `busy` drops and `done` rises. `done` stays high until the next `start`.
- R10: `mem_we` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to run the test |
| mem_addr | output | AW | Cell address, row*COLS+col |
| mem_we | output | 1 | Write enable to the memory |
| mem_wdata | output | 1 | Bit to write |
| mem_rdata | input | 1 | Read data, valid one cycle after the address |
| busy | output | 1 | Test in progress |
| done | output | 1 | Both phases finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | 1 | Expected bit at the first mismatch |

## Verification
The bench builds the block with 6 rows and 5 columns. This non-square grid, with an odd column count, is small enough that a full run of both phases takes under two thousand cycles. It still contains interior base cells that have all four neighbors, edge cells and corner cells. Row and column counts that are not powers of two also exercise the wrap of the address counter. The bench memory can force a chosen base cell to a fixed value under a chosen neighbor pattern. This places a fault on an interior cell that shows up in phase 0, and a fault on a corner cell that shows up only in phase 1 and then repeats several times.

// File: rtl/npsf_tester.sv
module npsf_tester #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int AW = (CELLS > 2) ? $clog2(CELLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_wdata,
  input  logic          mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic          fail_exp
);
  localparam int RW = ($clog2(ROWS) < 2) ? 2 : $clog2(ROWS);
  localparam int CW = ($clog2(COLS) < 2) ? 2 : $clog2(COLS);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_TAIL, S_END} st_t;

  st_t           st;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [AW-1:0] addr;
  logic [3:0]    step;
  logic          phase;
  logic          rd_v, rd_e;
  logic [AW-1:0] rd_a;

  wire       row_end   = (row == RW'(ROWS - 1));
  wire       col_end   = (col == CW'(COLS - 1));
  wire       last_cell = row_end && col_end;
  wire       is_base   = ~(row[0] ^ col[0]);
  wire [3:0] gray      = step ^ {1'b0, step[3:1]};
  wire [1:0] cls       = {row[0], row[1] ^ col[1]};

  assign mem_addr  = addr;
  assign mem_we    = (st == S_WR) && (!is_base || step == 4'd0);
  assign mem_wdata = is_base ? phase : gray[cls];
  assign busy      = (st == S_WR) || (st == S_RD) || (st == S_TAIL);
  assign done      = (st == S_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      row       <= '0;
      col       <= '0;
      addr      <= '0;
      step      <= '0;
      phase     <= 1'b0;
      rd_v      <= 1'b0;
      rd_a      <= '0;
      rd_e      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= 1'b0;
    end else begin
      rd_v <= (st == S_RD) && is_base;
      rd_a <= addr;
      rd_e <= phase;
      if (rd_v && (mem_rdata != rd_e) && !fail) begin
        fail      <= 1'b1;
        fail_addr <= rd_a;
        fail_exp  <= rd_e;
      end
      case (st)
        S_IDLE, S_END: begin
          if (start) begin
            st        <= S_WR;
            row       <= '0;
            col       <= '0;
            addr      <= '0;
            step      <= '0;
            phase     <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= 1'b0;
          end
        end
        S_WR, S_RD: begin
          if (col_end) begin
            col <= '0;
            row <= row_end ? '0 : row + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
          addr <= last_cell ? '0 : addr + 1'b1;
          if (last_cell) begin
            if (st == S_WR) begin
              st <= S_RD;
            end else if (step != 4'd15) begin
              step <= step + 1'b1;
              st   <= S_WR;
            end else if (!phase) begin
              phase <= 1'b1;
              step  <= '0;
              st    <= S_WR;
            end else begin
              st <= S_TAIL;
            end
          end
        end
        S_TAIL:  st <= S_END;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/npsf_tester_chk.sv
module npsf_tester_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int AW = (CELLS > 2) ? $clog2(CELLS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          fail,
  input logic [AW-1:0] fail_addr,
  input logic          fail_exp
);
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (int'(mem_addr) < CELLS)); // R3
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (fail && !start) |=> fail); // R8
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fail && !start) |=> ($stable(fail_addr) && $stable(fail_exp))); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done); // R9
  AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_we); // R10
endmodule

bind npsf_tester npsf_tester_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_addr(mem_addr), .fail(fail),
  .fail_addr(fail_addr), .fail_exp(fail_exp)
);

// File: tb/npsf_tester_tb.sv
module npsf_tester_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 6;
  localparam int COLS = 5;
  localparam int N = ROWS * COLS;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_wdata;
  logic          mem_rdata = 1'b0;
  logic          busy, done, fail, fail_exp;
  logic [AW-1:0] fail_addr;

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  npsf_tester #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp)
  );

  // Memory model with one injectable neighborhood fault.
  bit mem [N];
  bit f_on = 0;
  int f_addr = 0;
  bit f_val = 0;
  bit f_need [4];   // N, S, W, E
  bit f_use  [4];

  function automatic bit rd_cell(int a);
    int r, c;
    bit ok;
    r  = a / COLS;
    c  = a % COLS;
    ok = 1;
    if (!f_on || a != f_addr) return mem[a];
    if (f_use[0] && r > 0        && mem[a - COLS] != f_need[0]) ok = 0;
    if (f_use[1] && r < ROWS - 1 && mem[a + COLS] != f_need[1]) ok = 0;
    if (f_use[2] && c > 0        && mem[a - 1]    != f_need[2]) ok = 0;
    if (f_use[3] && c < COLS - 1 && mem[a + 1]    != f_need[3]) ok = 0;
    return ok ? f_val : mem[a];
  endfunction

  always @(posedge clk) begin
    mem_rdata <= rd_cell(int'(mem_addr));
    if (mem_we) mem[int'(mem_addr)] <= mem_wdata;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  typedef struct {
    bit we;
    int addr;
    bit wd;
    bit base_rd;
    bit ph;
  } op_t;

  op_t q[$];

  task automatic build_ops();
    q.delete();
    for (int ph = 0; ph < 2; ph++) begin
      for (int s = 0; s < 16; s++) begin
        int g;
        g = s ^ (s >> 1);
        for (int a = 0; a < N; a++) begin
          int r, c, k;
          bit base;
          op_t o;
          r    = a / COLS;
          c    = a % COLS;
          base = ((r + c) % 2) == 0;
          k    = 2 * (r % 2) + (((r / 2) % 2) ^ ((c / 2) % 2));
          o.we = !base || s == 0;
          o.addr = a;
          o.wd = base ? bit'(ph) : bit'((g >> k) & 1);
          o.base_rd = 0;
          o.ph = bit'(ph);
          q.push_back(o);
        end
        for (int a = 0; a < N; a++) begin
          op_t o;
          o.we = 0;
          o.addr = a;
          o.wd = 0;
          o.base_rd = (((a / COLS) + (a % COLS)) % 2) == 0;
          o.ph = bit'(ph);
          q.push_back(o);
        end
      end
    end
  endtask

  // Reference fail state, one cycle behind the read data.
  bit rf, rf_exp, pend, pend_exp;
  int rf_addr, pend_addr;

  task automatic ref_step();
    chk(fail === rf, "R8 fail flag", int'(fail), int'(rf));
    if (rf) begin
      chk(int'(fail_addr) == rf_addr, "R8 fail_addr", int'(fail_addr), rf_addr);
      chk(fail_exp === rf_exp, "R8 fail_exp", int'(fail_exp), int'(rf_exp));
    end
    if (pend && mem_rdata !== pend_exp && !rf) begin
      rf      = 1;
      rf_addr = pend_addr;
      rf_exp  = pend_exp;
    end
    pend = 0;
  endtask

  task automatic run_test(int poke_at);
    int idx;
    build_ops();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    rf = 0;
    pend = 0;
    idx = 0;
    while (q.size() > 0) begin
      op_t o;
      o = q.pop_front();
      ref_step();
      chk(busy === 1'b1 && done === 1'b0, "R2 busy during run", int'(busy), 1);
      chk(mem_we === o.we, "R5/R6 write enable", int'(mem_we), int'(o.we));
      chk(int'(mem_addr) == o.addr, "R3/R4 address order", int'(mem_addr), o.addr);
      if (o.we) chk(mem_wdata === o.wd, "R5 write data", int'(mem_wdata), int'(o.wd));
      if (o.base_rd) begin
        pend = 1;
        pend_addr = o.addr;
        pend_exp = o.ph;
      end
      start = (idx == poke_at);   // R2: ignored while busy
      idx++;
      @(negedge clk);
      start = 0;
    end
    ref_step();
    chk(busy === 1'b1 && done === 1'b0, "R9 tail cycle", int'(done), 0);
    @(negedge clk);
    ref_step();
    chk(done === 1'b1 && busy === 1'b0, "R9 done after phase 1", int'(done), 1);
    chk(mem_we === 1'b0, "R10 no write when idle", int'(mem_we), 0);
    @(negedge clk);
    chk(done === 1'b1, "R9 done held", int'(done), 1);
  endtask

  initial begin
    for (int a = 0; a < N; a++) mem[a] = 0;
    for (int i = 0; i < 4; i++) begin
      f_need[i] = 0;
      f_use[i] = 0;
    end
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", int'(busy) + int'(done), 0);
    chk(fail === 1'b0 && mem_we === 1'b0, "R1 reset fail/we", int'(fail) + int'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && fail === 1'b0 && mem_we === 1'b0, "R1 after reset", int'(busy), 0);

    // Fault-free run, with a start pulse while busy.
    run_test(100);
    chk(fail === 1'b0, "R6 clean memory passes", int'(fail), 0);

    // Interior base cell (2,2) forced to 1 under N=1 S=0 W=1 E=1.
    f_on = 1; f_addr = 2 * COLS + 2; f_val = 1;
    f_need[0] = 1; f_need[1] = 0; f_need[2] = 1; f_need[3] = 1;
    for (int i = 0; i < 4; i++) f_use[i] = 1;
    run_test(-1);
    chk(fail === 1'b1, "R8 interior fault flagged", int'(fail), 1);
    chk(int'(fail_addr) == 12, "R8 interior fault address", int'(fail_addr), 12);
    chk(fail_exp === 1'b0, "R8 interior fault expected bit", int'(fail_exp), 0);

    // Corner base cell (0,0) forced to 0 when its south and east cells are 1.
    f_addr = 0; f_val = 0;
    f_use[0] = 0; f_use[2] = 0;
    f_need[1] = 1; f_need[3] = 1;
    run_test(500);
    chk(fail === 1'b1, "R7 corner fault flagged", int'(fail), 1);
    chk(int'(fail_addr) == 0, "R7 corner fault address", int'(fail_addr), 0);
    chk(fail_exp === 1'b1, "R7 corner fault in phase 1", int'(fail_exp), 1);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    finished = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule